// File: doc/BRIEF.md
# Second-Order Pulse-Density Modulator for an Oversampled DAC

This block turns a signed multi-bit sample stream, arriving at the oversampled rate, into a single-bit pulse-density stream for a one-bit digital-to-analog output stage. Two saturating accumulators run in cascade. A one-bit quantizer reads the sign of the second accumulator. Its decision is fed back to both accumulators as plus or minus full scale, where full scale is 2^(IN_W-1). As a result the quantization error is pushed towards high frequencies with a (1 - z^-1)^2 shape, while the input passes through with one sample of delay. For the usual oversampling ratios of 8 to 256, the in-band error then becomes small.

Two measures keep the loop stable. Each accumulator is four bits wider than the input and clamps at its extremes instead of wrapping. A run-length monitor watches the output. When the output has held the same value for RUN_LIMIT enabled samples, it zeroes both accumulators on the next enabled cycle and raises a one-clock status pulse. State advances only on cycles where the oversampling enable is high.

Top module: `sdm2_dac_mod`

## Requirements
- R1: Synchronous active-low reset zeroes both accumulators and the run counter. After reset the output bit is 1 (a zero second accumulator counts as positive) and the status pulse is 0.
- R2: While the enable is low, no state changes. The output bit holds its value and the status pulse is 0, whatever the input sample.
- R3: On each enabled cycle without a stability clear, the block applies the following update. Let f = +2^(IN_W-1) when the current output is 1 and -2^(IN_W-1) when it is 0. The first accumulator becomes a1' = clamp(a1 + x - f). The second becomes a2' = clamp(a2 + a1' - f). The output is 1 exactly when a2 >= 0.
- R4: A zero input applied from reset gives exactly half ones over any window of 256 enabled samples that starts at reset.
- R5: A constant input x gives a one-density within 1/OSR of (x + 2^(IN_W-1)) / 2^IN_W over a window of 4*OSR enabled samples after settling.
- R6: Both accumulators saturate at -2^(ACC_W-1) and 2^(ACC_W-1)-1, with ACC_W = IN_W + 4, and never wrap.
- R7: After RUN_LIMIT consecutive enabled samples of equal output value, the next enabled cycle zeroes both accumulators instead of updating them. During the following clock the status pulse is 1 for exactly one cycle and the output bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Oversampling-rate enable; state advances only when high |
| x_i | input | IN_W | Signed input sample, two's complement |
| bit_o | output | 1 | Pulse-density output bit |
| stab_rst_o | output | 1 | One-clock pulse after a run-length stability clear |

## Verification
The assertions assume that the enable is the only thing that gates state, that any input code is legal including the most negative one, and that a stability clear can only follow an enabled cycle. The run-length property counts runs only over enabled samples, so gaps in the enable are allowed. The stimulus changes the sample and the enable half a cycle away from the active edge. It includes stretches with the enable low, constant inputs at zero, at moderate levels and at both extremes of full scale, and random inputs under a random enable. The negative extreme deliberately drives the accumulators into the clamp and makes the output stick, so the clear path is exercised repeatedly.

// File: rtl/sdm2_pkg.sv
`timescale 1ns/1ps
package sdm2_pkg;
  // extra accumulator bits above the input width
  localparam int unsigned SDM_GUARD_BITS = 4;
  // number of cascaded accumulators in the loop
  localparam int unsigned SDM_STAGES     = 2;
endpackage

// File: rtl/sdm2_integ.sv
`timescale 1ns/1ps
// One saturating accumulator stage with two-level feedback.
module sdm2_integ #(
  parameter int IN_W  = 16,
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic                    clr_i,
  input  logic                    fb_pos_i,
  input  logic signed [ACC_W-1:0] add_i,
  output logic signed [ACC_W-1:0] sum_o,
  output logic signed [ACC_W-1:0] acc_o
);
  localparam int SW = ACC_W + 2;
  localparam logic signed [SW-1:0] FB_MAG =
    {{(SW-IN_W){1'b0}}, 1'b1, {(IN_W-1){1'b0}}};
  localparam logic signed [SW-1:0] MAXV = {3'b000, {(ACC_W-1){1'b1}}};
  localparam logic signed [SW-1:0] MINV = {3'b111, {(ACC_W-1){1'b0}}};

  // clamp a wide sum into the accumulator range
  function automatic logic signed [ACC_W-1:0] clamp_acc(
      input logic signed [SW-1:0] v);
    if (v > MAXV)      return MAXV[ACC_W-1:0];
    else if (v < MINV) return MINV[ACC_W-1:0];
    else               return v[ACC_W-1:0];
  endfunction

  // widen by sign extension
  function automatic logic signed [SW-1:0] widen(
      input logic signed [ACC_W-1:0] v);
    return {{2{v[ACC_W-1]}}, v};
  endfunction

  logic signed [SW-1:0] fb_w;
  logic signed [SW-1:0] wide_w;
  logic signed [ACC_W-1:0] acc_q;

  assign fb_w   = fb_pos_i ? FB_MAG : -FB_MAG;
  assign wide_w = widen(acc_q) + widen(add_i) - fb_w;
  assign sum_o  = clamp_acc(wide_w);
  assign acc_o  = acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n)        acc_q <= '0;
    else if (en_i)     acc_q <= clr_i ? '0 : sum_o;
  end
endmodule

// File: rtl/sdm2_runlen.sv
`timescale 1ns/1ps
// Counts consecutive equal output samples; flags a stall at the limit.
module sdm2_runlen #(
  parameter int RUN_LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic bit_i,
  output logic stall_o
);
  localparam int CW = $clog2(RUN_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(RUN_LIMIT);

  logic [CW-1:0] cnt_q;
  logic          last_q;
  logic          same_w;

  assign same_w  = (bit_i == last_q) && (cnt_q != '0);
  assign stall_o = (cnt_q == LIM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      last_q <= 1'b0;
    end else if (en_i) begin
      last_q <= bit_i;
      if (stall_o)     cnt_q <= '0;
      else if (same_w) cnt_q <= cnt_q + 1'b1;
      else             cnt_q <= CW'(1);
    end
  end
endmodule

// File: rtl/sdm2_dac_mod.sv
`timescale 1ns/1ps
// Second-order one-bit modulator with clamping and run-length stability clear.
module sdm2_dac_mod
  import sdm2_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int RUN_LIMIT = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_i,
  input  logic [IN_W-1:0] x_i,
  output logic            bit_o,
  output logic            stab_rst_o
);
  localparam int ACC_W = IN_W + int'(SDM_GUARD_BITS);
  localparam int NST   = int'(SDM_STAGES);

  logic signed [ACC_W-1:0] stg_add [NST];
  logic signed [ACC_W-1:0] stg_sum [NST];
  logic signed [ACC_W-1:0] stg_acc [NST];

  logic quant_pos;   // quantizer decision from last stage sign
  logic run_stall;   // run-length limit reached
  logic clear_evt;   // accumulators cleared on this edge
  logic flag_q;

  assign quant_pos = ~stg_acc[NST-1][ACC_W-1];
  assign clear_evt = en_i & run_stall;

  for (genvar g = 0; g < NST; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stg_add[g] = {{(ACC_W-IN_W){x_i[IN_W-1]}}, x_i};
    end else begin : g_next
      assign stg_add[g] = stg_sum[g-1];
    end
    sdm2_integ #(.IN_W(IN_W), .ACC_W(ACC_W)) u_integ (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (en_i),
      .clr_i    (run_stall),
      .fb_pos_i (quant_pos),
      .add_i    (stg_add[g]),
      .sum_o    (stg_sum[g]),
      .acc_o    (stg_acc[g])
    );
  end

  sdm2_runlen #(.RUN_LIMIT(RUN_LIMIT)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .bit_i   (quant_pos),
    .stall_o (run_stall)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= clear_evt;
  end

  assign bit_o      = quant_pos;
  assign stab_rst_o = flag_q;
endmodule

// File: rtl/sdm2_dac_mod_chk.sv
`timescale 1ns/1ps
module sdm2_dac_mod_chk #(
  parameter int RUN_LIMIT = 64
) (
  input logic clk,
  input logic rst_n,
  input logic en_i,
  input logic bit_o,
  input logic stab_rst_o,
  input logic stall_i
);
  localparam int CW = $clog2(RUN_LIMIT + 2) + 1;
  logic [CW-1:0] run_cnt;
  logic          run_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt  <= '0;
      run_last <= 1'b0;
    end else if (stab_rst_o) begin
      run_cnt  <= en_i ? CW'(1) : '0;
      run_last <= bit_o;
    end else if (en_i) begin
      run_last <= bit_o;
      run_cnt  <= (bit_o == run_last && run_cnt != '0) ? run_cnt + 1'b1 : CW'(1);
    end
  end

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(bit_o) && !stab_rst_o));

  p_run_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= CW'(RUN_LIMIT + 1));

  p_flag_out_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stab_rst_o |-> bit_o);

  p_flag_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stab_rst_o |=> !stab_rst_o);

  p_stall_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && en_i) |=> stab_rst_o);
endmodule

bind sdm2_dac_mod sdm2_dac_mod_chk #(.RUN_LIMIT(RUN_LIMIT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en_i       (en_i),
  .bit_o      (bit_o),
  .stab_rst_o (stab_rst_o),
  .stall_i    (run_stall)
);

// File: tb/sdm2_dac_mod_tb.sv
`timescale 1ns/1ps
module sdm2_dac_mod_tb;
  localparam int IN_W  = 16;
  localparam int LIMIT = 64;
  localparam int OSR   = 256;
  localparam int FS    = 1 << (IN_W - 1);
  localparam int AMAX  = (1 << (IN_W + 3)) - 1;
  localparam int AMIN  = -(1 << (IN_W + 3));

  typedef struct { logic b; logic f; string tag; } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0;
  logic [IN_W-1:0] x = '0;
  logic bit_o, stab_rst_o;

  int checks = 0, errors = 0, ones = 0, flags_seen = 0;
  bit finished = 1'b0;
  exp_t q[$];

  // reference state
  int m_a1, m_a2, m_run;
  logic m_last, m_flag;

  always #4 clk = ~clk;

  sdm2_dac_mod #(.IN_W(IN_W), .RUN_LIMIT(LIMIT)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .x_i(x),
    .bit_o(bit_o), .stab_rst_o(stab_rst_o));

  function automatic int clip(input int v);
    if (v > AMAX) return AMAX;
    if (v < AMIN) return AMIN;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_a1 = 0; m_a2 = 0; m_run = 0; m_last = 1'b0; m_flag = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    repeat (2) @(negedge clk);
    model_reset();
    rst_n = 1'b1;
  endtask

  // driver: one cycle of stimulus, expectation pushed for after the edge
  task automatic step(input logic e, input int xv, input string tag);
    logic b;
    int f;
    @(negedge clk);
    en = e;
    x  = IN_W'(xv);
    b  = (m_a2 >= 0);
    if (e) ones += int'(bit_o);
    m_flag = 1'b0;
    if (e) begin
      if (m_run >= LIMIT) begin
        m_a1 = 0; m_a2 = 0; m_run = 0; m_flag = 1'b1;
      end else begin
        f = b ? FS : -FS;
        m_a1 = clip(m_a1 + xv - f);
        m_a2 = clip(m_a2 + m_a1 - f);
        m_run = (b == m_last && m_run != 0) ? m_run + 1 : 1;
      end
      m_last = b;
    end
    q.push_back('{b: (m_a2 >= 0), f: m_flag, tag: tag});
  endtask

  // monitor: compare once the edge has settled
  always @(posedge clk) begin
    exp_t it;
    #2;
    if (q.size() != 0) begin
      it = q.pop_front();
      if (stab_rst_o) flags_seen++;
      checks++;
      if (bit_o !== it.b || stab_rst_o !== it.f) begin
        errors++;
        $display("FAIL %s bit=%0b/flag=%0b expected bit=%0b/flag=%0b",
                 it.tag, bit_o, stab_rst_o, it.b, it.f);
      end
    end
  end

  task automatic density(input int xv, input int exp_ones, input string tag);
    do_reset();
    repeat (OSR) step(1'b1, xv, "R3");
    ones = 0;
    repeat (4 * OSR) step(1'b1, xv, "R3");
    check((ones >= exp_ones - 4) && (ones <= exp_ones + 4), tag, ones, exp_ones);
  endtask

  initial begin
    model_reset();
    do_reset();
    @(negedge clk);
    check(bit_o == 1'b1, "R1 bit after reset", int'(bit_o), 1);
    check(stab_rst_o == 1'b0, "R1 flag after reset", int'(stab_rst_o), 0);

    // R2: enable low, input varies, nothing moves
    for (int i = 0; i < 12; i++) step(1'b0, int'($urandom_range(65535)) - FS, "R2");

    // R4: zero input, exactly half ones
    do_reset();
    ones = 0;
    repeat (256) step(1'b1, 0, "R3 zero input");
    check(ones == 128, "R4 zero-input density", ones, 128);

    // R5: constant inputs
    density(FS / 2, 768, "R5 density +FS/2");
    density(-FS / 4, 384, "R5 density -FS/4");
    density(FS / 8, 576, "R5 density +FS/8");

    // R7: most negative input sticks the output and triggers clears
    do_reset();
    flags_seen = 0;
    repeat (300) step(1'b1, -FS, "R7 run-length clear");
    repeat (2) @(negedge clk);
    check(flags_seen >= 3, "R7 clears observed", flags_seen, 3);

    // R6: drive into clamp, then swing to the other extreme
    do_reset();
    repeat (40) step(1'b1, -FS, "R6 clamp low");
    repeat (200) step(1'b1, FS - 1, "R6 recover from clamp");

    // R3: random input under random enable
    do_reset();
    for (int i = 0; i < 600; i++)
      step(($urandom_range(9) < 7), int'($urandom_range(65535)) - FS, "R3 random");
    repeat (3) @(negedge clk);

    if (!finished) begin
      finished = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule